// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Update Unit

This block advances one leaky integrate-and-fire neuron by a single time step per transaction. For each neuron the caller presents the old membrane potential, the neuron's own decay factor, the synaptic current already summed for this step, and the spike bit that the neuron produced on the previous step. The block scales the potential by the decay factor and adds the current. If the neuron fired last time, it takes the firing threshold off the result. It then compares the new potential with the threshold to decide the new spike. Every sum saturates at the signed limits of the potential word instead of wrapping.

The threshold comes from a configuration input that stays constant for a whole inference. Transactions enter and leave through valid/ready handshakes. The result is registered, so an accepted input appears at the output on the next clock. A full output register waits while the consumer is not ready. A small state machine has two states. `ST_EMPTY` means the output register holds nothing. `ST_FULL` means it holds a result that has not been taken yet. There are four transitions:
- `LOAD` (EMPTY to FULL) on an accepted input.
- `STALL` (FULL to FULL) while the output is not taken.
- `RELOAD` (FULL to FULL) when the output is taken and a new input is accepted in the same cycle.
- `DRAIN` (FULL to EMPTY) when the output is taken and no input arrives.

Top module: `lif_neuron_unit`

## Requirements
- R1: The decay term is the signed potential times the decay factor, which is read as an unsigned fraction (value / 2^14). The product is arithmetic-shifted right by 14 bits, so it rounds toward minus infinity (for example -3 with factor 8192 gives -2).
- R2: The synaptic current is added to the decay term with a saturating signed addition.
- R3: When the previous spike bit is 1, the threshold is subtracted from the sum with saturation. When it is 0, the sum passes unchanged. The potential is never forced to zero.
- R4: The output spike is 1 exactly when the new potential is strictly greater than the signed threshold. A potential equal to the threshold gives 0.
- R5: Every addition and subtraction clamps to 2^31-1 on positive overflow and to -2^31 on negative overflow.
- R6: An input accepted at a clock edge (in_valid and in_ready both high) shows up with out_valid high after that edge. When out_valid is high, out_ready is high and no input is accepted, out_valid is low after the next edge.
- R7: While out_valid is high and out_ready is low, in_ready is low and out_potential and out_spike keep their values.
- R8: in_ready is high whenever the output register is empty or is being taken. With out_ready held high, a new input is accepted every cycle and each result appears one cycle later.
- R9: After reset, out_valid is low, in_ready is high, and out_potential and out_spike are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_threshold | input | 32 | Signed firing threshold, constant during an inference |
| in_valid | input | 1 | Input transaction offered |
| in_ready | output | 1 | Input transaction can be taken |
| in_potential | input | 32 | Previous signed membrane potential |
| in_decay | input | 14 | Unsigned decay fraction, value / 2^14 |
| in_current | input | 32 | Signed summed synaptic current |
| in_prev_spike | input | 1 | Spike produced on the previous step |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_potential | output | 32 | New signed membrane potential |
| out_spike | output | 1 | New spike bit |

## Verification
The bench uses the default widths: a 32-bit potential and a 14-bit decay with 14 fraction bits. At these widths the extreme decay factors 0 and 16383 and the two signed limits of the potential can all be driven directly. This reaches both saturation directions and the rounding of negative products. A threshold of 1000 places the equal-to-threshold and one-above cases inside the vector table. A separate negative threshold checks that the comparison is signed.

// File: rtl/lif_pkg.sv
package lif_pkg;
    parameter int unsigned POT_W  = 32;
    parameter int unsigned DEC_W  = 14;
    parameter int unsigned FRAC_W = 14;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } lif_state_e;
endpackage

// File: rtl/lif_decay_mult.sv
module lif_decay_mult #(
    parameter int unsigned POT_W  = 32,
    parameter int unsigned DEC_W  = 14,
    parameter int unsigned FRAC_W = 14
) (
    input  logic signed [POT_W-1:0] potential,
    input  logic        [DEC_W-1:0] decay,
    output logic signed [POT_W-1:0] scaled
);
    localparam int unsigned PROD_W = POT_W + DEC_W;

    logic signed [PROD_W-1:0] pot_ext;
    logic signed [PROD_W-1:0] partial [0:DEC_W];
    logic signed [PROD_W-1:0] shifted;
    logic                     unused_frac_bits;

    assign pot_ext    = PROD_W'(potential);
    assign partial[0] = '0;

    // shift-and-add array: one adder row per decay bit
    for (genvar b = 0; b < DEC_W; b++) begin : g_row
        assign partial[b+1] = partial[b] + (decay[b] ? (pot_ext <<< b) : '0);
    end

    assign shifted          = partial[DEC_W] >>> FRAC_W;
    assign scaled           = shifted[POT_W-1:0];
    assign unused_frac_bits = ^shifted[PROD_W-1:POT_W];
endmodule

// File: rtl/lif_sat_addsub.sv
module lif_sat_addsub #(
    parameter int unsigned W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                subtract,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] a_ext;
    logic signed [W:0] b_ext;
    logic signed [W:0] raw;

    always_comb begin
        a_ext = {a[W-1], a};
        b_ext = {b[W-1], b};
        raw   = subtract ? (a_ext - b_ext) : (a_ext + b_ext);
        if (raw[W] != raw[W-1]) begin
            y = raw[W] ? MIN_V : MAX_V;
        end else begin
            y = raw[W-1:0];
        end
    end
endmodule

// File: rtl/lif_datapath.sv
module lif_datapath #(
    parameter int unsigned POT_W  = 32,
    parameter int unsigned DEC_W  = 14,
    parameter int unsigned FRAC_W = 14
) (
    input  logic signed [POT_W-1:0] threshold,
    input  logic signed [POT_W-1:0] potential,
    input  logic        [DEC_W-1:0] decay,
    input  logic signed [POT_W-1:0] current,
    input  logic                    prev_spike,
    output logic signed [POT_W-1:0] next_potential,
    output logic                    next_spike
);
    logic signed [POT_W-1:0] leaked;
    logic signed [POT_W-1:0] integrated;
    logic signed [POT_W-1:0] reset_amount;

    lif_decay_mult #(
        .POT_W (POT_W),
        .DEC_W (DEC_W),
        .FRAC_W(FRAC_W)
    ) u_mult (
        .potential(potential),
        .decay    (decay),
        .scaled   (leaked)
    );

    lif_sat_addsub #(.W(POT_W)) u_integrate (
        .a       (leaked),
        .b       (current),
        .subtract(1'b0),
        .y       (integrated)
    );

    assign reset_amount = prev_spike ? threshold : '0;

    lif_sat_addsub #(.W(POT_W)) u_reset (
        .a       (integrated),
        .b       (reset_amount),
        .subtract(1'b1),
        .y       (next_potential)
    );

    assign next_spike = (next_potential > threshold);
endmodule

// File: rtl/lif_neuron_unit.sv
module lif_neuron_unit
    import lif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] cfg_threshold,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_potential,
    input  logic [13:0] in_decay,
    input  logic [31:0] in_current,
    input  logic        in_prev_spike,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_potential,
    output logic        out_spike
);
    lif_state_e state_q, state_d;
    logic signed [POT_W-1:0] next_pot;
    logic                    next_spk;
    logic                    accept;
    logic signed [POT_W-1:0] pot_q;
    logic                    spk_q;

    lif_datapath #(
        .POT_W (POT_W),
        .DEC_W (DEC_W),
        .FRAC_W(FRAC_W)
    ) u_dp (
        .threshold     (cfg_threshold),
        .potential     (in_potential),
        .decay         (in_decay),
        .current       (in_current),
        .prev_spike    (in_prev_spike),
        .next_potential(next_pot),
        .next_spike    (next_spk)
    );

    assign in_ready = (state_q == ST_EMPTY) || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;             // LOAD
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY; // DRAIN, else STALL/RELOAD
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pot_q <= '0;
            spk_q <= 1'b0;
        end else if (accept) begin
            pot_q <= next_pot;
            spk_q <= next_spk;
        end
    end

    assign out_valid     = (state_q == ST_FULL);
    assign out_potential = pot_q;
    assign out_spike     = spk_q;
endmodule

// File: rtl/lif_neuron_unit_chk.sv
module lif_neuron_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_threshold,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_potential,
    input logic        out_spike
);
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_potential) && $stable(out_spike)); // R7
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R7
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R6
    AST_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid); // R6
    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8
    AST_SPIKE_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $stable(cfg_threshold) |-> out_spike == ($signed(out_potential) > $signed(cfg_threshold))); // R4
endmodule

bind lif_neuron_unit lif_neuron_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_threshold(cfg_threshold),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_potential(out_potential),
    .out_spike    (out_spike)
);

// File: tb/test_lif_neuron_unit.sv
`timescale 1ns/1ps
module test_lif_neuron_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_threshold = 32'd1000;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_potential = '0;
    logic [13:0] in_decay = '0;
    logic [31:0] in_current = '0;
    logic        in_prev_spike = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_potential;
    logic        out_spike;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lif_neuron_unit i_lif_neuron_unit (
        .clk(clk), .rst_n(rst_n), .cfg_threshold(cfg_threshold),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_potential(in_potential), .in_decay(in_decay),
        .in_current(in_current), .in_prev_spike(in_prev_spike),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_potential(out_potential), .out_spike(out_spike)
    );

    // stimulus: {potential, decay, current, prev_spike}
    localparam int NV = 10;
    localparam logic [78:0] VEC [NV] = '{
        {32'd1000,        14'd8192,  32'd0,           1'b0}, // R1 half decay
        {-32'sd1000,      14'd8192,  32'd0,           1'b0}, // R1 negative
        {-32'sd3,         14'd8192,  32'd0,           1'b0}, // R1 floor to -2
        {32'd2000,        14'd16383, 32'd100,         1'b1}, // R3 subtract, spike
        {32'd0,           14'd0,     32'd1000,        1'b0}, // R4 equal -> no spike
        {32'd0,           14'd0,     32'd1001,        1'b0}, // R4 above -> spike
        {32'h7fffffff,    14'd16383, 32'h7fffffff,    1'b0}, // R5 positive clamp
        {32'h80000000,    14'd16383, 32'h80000000,    1'b1}, // R5 negative clamp
        {32'd500,         14'd0,     -32'sd200,       1'b1}, // R2 R3 current and reset
        {32'd12345,       14'd1000,  32'd77,          1'b0}  // R2 plain
    };

    function automatic longint sat32(input longint x);
        if (x > 64'sd2147483647)  return 64'sd2147483647;
        if (x < -64'sd2147483648) return -64'sd2147483648;
        return x;
    endfunction

    function automatic logic [32:0] model(input logic [31:0] v, input logic [13:0] d,
                                          input logic [31:0] c, input logic s,
                                          input logic [31:0] t);
        longint p, r;
        p = (longint'($signed(v)) * longint'({18'd0, d})) >>> 14;
        r = sat32(p + longint'($signed(c)));
        if (s) r = sat32(r - longint'($signed(t)));
        return {(r > longint'($signed(t))), r[31:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [78:0] vec);
        {in_potential, in_decay, in_current, in_prev_spike} = vec;
        in_valid = 1'b1;
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [32:0] exp;
        logic [32:0] held;
        repeat (2) @(negedge clk);
        check("R9 out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 in_ready", {31'd0, in_ready}, 32'd1);
        check("R9 potential", out_potential, 32'd0);
        check("R9 spike", {31'd0, out_spike}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, one transaction at a time
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            exp = model(VEC[i][78:47], VEC[i][46:33], VEC[i][32:1], VEC[i][0], cfg_threshold);
            @(negedge clk);
            in_valid = 1'b0;
            check("R6 valid after accept", {31'd0, out_valid}, 32'd1);
            check("R1 R2 R3 R5 potential", out_potential, exp[31:0]);
            check("R4 spike", {31'd0, out_spike}, {31'd0, exp[32]});
            @(negedge clk);
            check("R6 drained", {31'd0, out_valid}, 32'd0);
        end

        // R4 with a negative threshold: signed compare
        cfg_threshold = -32'sd5;
        drive({-32'sd4, 14'd0, 32'd0, 1'b0});
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 signed threshold potential", out_potential, 32'd0);
        check("R4 signed threshold spike", {31'd0, out_spike}, 32'd1);
        @(negedge clk);
        cfg_threshold = 32'd1000;

        // R7 backpressure
        out_ready = 1'b0;
        drive(VEC[0]);
        @(negedge clk);
        held = {out_spike, out_potential};
        drive(VEC[5]);
        repeat (3) begin
            @(negedge clk);
            check("R7 in_ready low", {31'd0, in_ready}, 32'd0);
            check("R7 potential held", out_potential, held[31:0]);
            check("R7 valid held", {31'd0, out_valid}, 32'd1);
        end
        out_ready = 1'b1;
        exp = model(VEC[5][78:47], VEC[5][46:33], VEC[5][32:1], VEC[5][0], cfg_threshold);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 R8 reload potential", out_potential, exp[31:0]);
        check("R7 R8 reload spike", {31'd0, out_spike}, {31'd0, exp[32]});
        @(negedge clk);

        // R8 back-to-back stream
        for (int i = 0; i < 5; i++) begin
            drive(VEC[i+3]);
            exp = model(VEC[i+3][78:47], VEC[i+3][46:33], VEC[i+3][32:1], VEC[i+3][0], cfg_threshold);
            check("R8 ready while streaming", {31'd0, in_ready}, 32'd1);
            @(negedge clk);
            check("R8 stream potential", out_potential, exp[31:0]);
            check("R8 stream valid", {31'd0, out_valid}, 32'd1);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R6 stream drained", {31'd0, out_valid}, 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule